// File: doc/BRIEF.md
# Bit-Plane LED Shift Driver

This block drives a row of LED channels that sit behind a chain of serial-in, parallel-out shift registers with an output latch. It uses binary code modulation. Each channel has a 12-bit brightness value. The block regroups these values into twelve bit-plane words of 32 bits each: word `i` holds bit `i` of every channel, and channel `c` sits at word bit `c`. The planes are shown one after another, and each plane stays on the outputs for a time that grows with its bit weight.

Each plane period runs as a fixed sequence:
1. The shift-register clear is asserted for a short dead band.
2. The plane word is shifted out inside a fixed transmission window.
3. At the window's end, a latch strobe pulse moves the shifted data to the outputs.
4. The outputs then hold for the weighted time.

The length of the next period is loaded ahead of time and takes effect at the rollover, so each frame has exactly the same number of ticks. One timer tick is one clock cycle.

Software-side logic writes channel values through a simple write port. It then pulses `update`. That pulse takes a snapshot of all planes, and the snapshot is put on display only when plane 0 next begins. A frame is therefore never built from two different snapshots.

Top module: `bcm_shift_driver`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` for channel `wr_addr`. After an update, bit `i` of that value appears at bit `c` of the word shifted for plane `i`.
- R2: Plane words are rebuilt from the channel values only on an `update` pulse. Channel writes made after the last update do not change any shifted word.
- R3: A new snapshot takes effect only at the start of plane 0. Every plane of a frame comes from the same snapshot, even when `update` arrives in the middle of a frame.
- R4: Planes are shown in the order 0, 1, …, 11, then wrap back to 0. The first plane after reset is plane 0.
- R5: The period for plane `i` lasts `WIN + DEAD + (BASE << i)` clock ticks. With the defaults this is 132 + 4·2^i.
- R6: In each period, exactly 32 serial clock pulses are sent, starting `DEAD` ticks after the period starts.
  - Each pulse is one tick low and then one tick high. `sclk` idles low.
  - Bits 15 down to 0 are sent first, then bits 31 down to 16. Within each 16-bit half the MSB goes first.
- R7: `sdo` changes only while `sclk` is low, so it is stable across every rising `sclk` edge.
- R8: `strobe` goes high `WIN` ticks after the period starts, stays high for exactly `DEAD` ticks, and pulses once per period.
- R9: `clear_n` is active low. It is low for exactly the first `DEAD` ticks of each period and is never low while `sclk` or `strobe` is high.
- R10: While `rst_n` is low, `strobe`, `sclk` and `sdo` are 0 and `clear_n` is 0 (clear asserted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timer tick |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Channel value write enable |
| wr_addr | input | 5 | Channel index to write |
| wr_data | input | 12 | Channel brightness value |
| update | input | 1 | Snapshot request; takes effect at the next plane 0 |
| sclk | output | 1 | Serial shift clock, idle low |
| sdo | output | 1 | Serial data to the register chain |
| strobe | output | 1 | Output latch strobe, active high |
| clear_n | output | 1 | Shift register clear, active low |

## Verification
The assertions check the following on every cycle:
- the plane counter steps and wraps correctly;
- the loaded period length matches the current plane;
- the snapshot and the displayed planes stay unchanged unless an update or a frame-start swap occurs;
- `sdo` never changes while `sclk` is high;
- clear is never asserted together with a clock pulse or a strobe.

Only the bench scenarios can show the following:
- the bit ordering of each shifted word;
- the channel-to-bit mapping;
- the exact period lengths across a whole frame;
- that writes made without an update stay invisible, and that an update issued mid-frame is held back until plane 0.

// File: rtl/bcm_pkg.sv
// Package: shared helpers for the bit-plane shift driver.
// Assumes: all arguments are small positive integers.
package bcm_pkg;

    // Period length in ticks for a given plane index.
    function automatic int period_ticks(int win, int dead, int base, int plane);
        return win + dead + (base << plane);
    endfunction

endpackage

// File: rtl/bcm_plane_store.sv
// Module: bcm_plane_store
// Holds the per-channel brightness values and regroups them into bit-plane
// words. An update pulse copies those words into a staging set. A frame-start
// swap moves the staging set into the displayed set, but only if a snapshot
// is pending.
// Assumes: swap_i is a single-cycle pulse at the rollover into plane 0.
module bcm_plane_store #(
    parameter int NCH = 32,
    parameter int NB  = 12,
    localparam int AW = $clog2(NCH),
    localparam int PW = $clog2(NB)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [NB-1:0]  wr_data,
    input  logic           update,
    input  logic           swap_i,
    input  logic [PW-1:0]  plane_sel,
    output logic [NCH-1:0] plane_word
);

    logic [NB-1:0]           bright_q [NCH];
    logic [NB-1:0][NCH-1:0]  xpose;
    logic [NB-1:0][NCH-1:0]  stage_q;
    logic [NB-1:0][NCH-1:0]  act_q;
    logic                    pend_q;

    // Brightness buffer: store one channel per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) bright_q[c] <= '0;
        end else if (wr_en) begin
            bright_q[wr_addr] <= wr_data;
        end
    end

    // Transpose: plane b, bit c is channel c, bit b.
    always_comb begin
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NCH; c++)
                xpose[b][c] = bright_q[c][b];
    end

    // Snapshot on update; displayed set swaps at frame start when pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            act_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (update) stage_q <= xpose;
            if (swap_i && pend_q) act_q <= stage_q;
            pend_q <= update ? 1'b1 : ((swap_i && pend_q) ? 1'b0 : pend_q);
        end
    end

    // Read the word for the plane being shown.
    assign plane_word = act_q[plane_sel];

    a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(stage_q));

    a_r3_swap_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> $stable(act_q));

endmodule

// File: rtl/bcm_period_timer.sv
// Module: bcm_period_timer
// Counts the ticks of each plane period and steps through the planes. The
// next period's length is preloaded during the current period and is taken
// over at the rollover.
// Assumes: every period is longer than two ticks.
module bcm_period_timer #(
    parameter int NB   = 12,
    parameter int WIN  = 128,
    parameter int DEAD = 4,
    parameter int BASE = 4,
    localparam int LMAX = WIN + DEAD + (BASE << (NB - 1)),
    localparam int CW   = $clog2(LMAX + 1),
    localparam int PW   = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt,
    output logic [PW-1:0] plane,
    output logic          frame_start
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] nxt_q;
    logic [PW-1:0] plane_q;
    logic [PW-1:0] plane_n;
    logic          roll;

    function automatic logic [CW-1:0] len_of(logic [PW-1:0] p);
        return CW'(bcm_pkg::period_ticks(WIN, DEAD, BASE, int'(p)));
    endfunction

    // Next plane index with wrap.
    assign plane_n = (plane_q == PW'(NB - 1)) ? '0 : plane_q + PW'(1);
    assign roll    = (cnt_q == len_q - CW'(1));

    // Tick counter, plane index and preloaded length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            plane_q <= '0;
            len_q   <= len_of('0);
            nxt_q   <= len_of(PW'(1));
        end else begin
            if (roll) begin
                cnt_q   <= '0;
                plane_q <= plane_n;
                len_q   <= nxt_q;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
            nxt_q <= len_of(plane_n);
        end
    end

    assign cnt         = cnt_q;
    assign plane       = plane_q;
    assign frame_start = roll && (plane_q == PW'(NB - 1));

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> plane_q == '0);

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (roll && plane_q != PW'(NB - 1)) |=> plane_q == $past(plane_q) + PW'(1));

    a_r5_len_matches: assert property (@(posedge clk) disable iff (!rst_n)
        len_q == len_of(plane_q));

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len_q);

endmodule

// File: rtl/bcm_serializer.sv
// Module: bcm_serializer
// Decodes the period tick count into the serial clock, the data bit, the
// latch strobe and the active-low clear.
// Assumes: NCH and HALF are powers of two, and WIN >= DEAD + 2*NCH.
module bcm_serializer #(
    parameter int NCH  = 32,
    parameter int HALF = 16,
    parameter int WIN  = 128,
    parameter int DEAD = 4,
    parameter int CW   = 14,
    localparam int KW  = $clog2(NCH),
    localparam int HW  = $clog2(HALF)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt,
    input  logic [NCH-1:0] word,
    output logic           sclk,
    output logic           sdo,
    output logic           strobe,
    output logic           clear_n
);

    localparam logic [CW-1:0] SH_BEG = CW'(DEAD);
    localparam logic [CW-1:0] SH_END = CW'(DEAD + 2 * NCH);
    localparam logic [CW-1:0] ST_BEG = CW'(WIN);
    localparam logic [CW-1:0] ST_END = CW'(WIN + DEAD);

    logic [CW-1:0] rel;
    logic [KW-1:0] k;
    logic [KW-1:0] bsel;
    logic          shifting;

    // Position inside the shift window.
    assign rel      = cnt - SH_BEG;
    assign k        = rel[KW:1];
    assign shifting = (cnt >= SH_BEG) && (cnt < SH_END);

    // Bit order: each half MSB first, halves from low to high.
    generate
        if (HALF == NCH) begin : g_one_half
            assign bsel = ~k;
        end else begin : g_halves
            assign bsel = {k[KW-1:HW], ~k[HW-1:0]};
        end
    endgenerate

    // Output decode.
    assign sclk    = shifting && rel[0];
    assign sdo     = shifting && word[bsel];
    assign strobe  = (cnt >= ST_BEG) && (cnt < ST_END);
    assign clear_n = (cnt >= SH_BEG);

    a_r7_sdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdo));

    a_r9_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk || strobe) |-> clear_n);

    a_r8_strobe_clear_of_shift: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !sclk);

    a_r10_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (!strobe && !sclk && !sdo && !clear_n));

endmodule

// File: rtl/bcm_shift_driver.sv
// Module: bcm_shift_driver (top)
// Bit-plane LED shift driver. Connects the plane store, the period timer and
// the serializer.
// Assumes: one clock cycle equals one timer tick.
module bcm_shift_driver #(
    parameter int NCH  = 32,
    parameter int NB   = 12,
    parameter int HALF = 16,
    parameter int WIN  = 128,
    parameter int DEAD = 4,
    parameter int BASE = 4,
    localparam int AW   = $clog2(NCH),
    localparam int PW   = $clog2(NB),
    localparam int LMAX = WIN + DEAD + (BASE << (NB - 1)),
    localparam int CW   = $clog2(LMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [NB-1:0] wr_data,
    input  logic          update,
    output logic          sclk,
    output logic          sdo,
    output logic          strobe,
    output logic          clear_n
);

    logic [CW-1:0]  cnt;
    logic [PW-1:0]  plane;
    logic           frame_start;
    logic [NCH-1:0] word;

    bcm_period_timer #(.NB(NB), .WIN(WIN), .DEAD(DEAD), .BASE(BASE)) u_timer (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .plane(plane), .frame_start(frame_start)
    );

    bcm_plane_store #(.NCH(NCH), .NB(NB)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .update(update), .swap_i(frame_start), .plane_sel(plane), .plane_word(word)
    );

    bcm_serializer #(.NCH(NCH), .HALF(HALF), .WIN(WIN), .DEAD(DEAD), .CW(CW)) u_ser (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .word(word),
        .sclk(sclk), .sdo(sdo), .strobe(strobe), .clear_n(clear_n)
    );

endmodule

// File: tb/bcm_shift_driver_tb.sv
module bcm_shift_driver_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 32;
    localparam int NB   = 12;
    localparam int WIN  = 128;
    localparam int DEAD = 4;
    localparam int BASE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        update = 1'b0;
    logic        sclk, sdo, strobe, clear_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [NCH-1:0] exp_q [$];
    logic [11:0]    model [NCH];
    int             strobe_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcm_shift_driver u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .update(update), .sclk(sclk), .sdo(sdo), .strobe(strobe), .clear_n(clear_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] plane_of(input int p);
        logic [NCH-1:0] w;
        for (int c = 0; c < NCH; c++) w[c] = model[c][p];
        return w;
    endfunction

    // Driver side: push the expected words of one whole frame.
    task automatic push_frame();
        for (int p = 0; p < NB; p++) exp_q.push_back(plane_of(p));
    endtask

    task automatic write_ch(input int c, input logic [11:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(c); wr_data = v;
        model[c] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk);
        update = 1'b1;
        @(negedge clk);
        update = 1'b0;
    endtask

    // Monitor state
    int             cyc = 0;
    bit             sclk_p = 1'b0, sdo_p = 1'b0, strobe_p = 1'b0, clear_p = 1'b0;
    int             nbits = 0;
    logic [NCH-1:0] got_word = '0;
    int             last_st = 0;
    int             st_rise = 0;
    int             clr_fall = 0;

    // Monitor: rebuild shifted words, pop and compare at each strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            // R7: sdo may only change while sclk is low
            if (sdo !== sdo_p && nbits > 0)
                check(sclk == 1'b0, "R7", "sdo changed while sclk high", sclk, 0);
            if (sclk && !sclk_p) begin
                int k;
                k = nbits;
                if (k < 16) got_word[15 - k] = sdo;
                else if (k < 32) got_word[47 - k] = sdo;
                nbits++;
                check(clear_n == 1'b1, "R9", "clear asserted during sclk pulse", clear_n, 1);
            end
            if (strobe && !strobe_p) begin
                int pl;
                string tag;
                logic [NCH-1:0] e;
                pl = strobe_cnt % NB;
                // R6: 32 clock pulses per period, low half then high half, MSB first
                check(nbits == NCH, "R6", "sclk pulses in period", nbits, NCH);
                check(clear_n == 1'b1, "R9", "clear asserted at strobe", clear_n, 1);
                tag = (strobe_cnt < 24) ? "R1" : ((strobe_cnt < 36) ? "R2" : "R3");
                if (exp_q.size() == 0) begin
                    check(1'b0, tag, "no expected plane queued", got_word, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(got_word == e, tag, $sformatf("plane %0d word", pl), got_word, e);
                end
                if (strobe_cnt > 0) begin
                    int pp, el;
                    pp = (strobe_cnt - 1) % NB;
                    el = WIN + DEAD + (BASE << pp);
                    // R5 length per plane; R4 order 0..11 with wrap shows in the sequence
                    check(cyc - last_st == el, "R5", $sformatf("period of plane %0d (R4 order)", pp),
                          cyc - last_st, el);
                end
                last_st = cyc;
                st_rise = cyc;
                strobe_cnt++;
                nbits = 0;
                got_word = '0;
            end
            if (!strobe && strobe_p)
                check(cyc - st_rise == DEAD, "R8", "strobe width", cyc - st_rise, DEAD);
            if (!clear_n && clear_p) clr_fall = cyc;
            if (clear_n && !clear_p && strobe_cnt > 0)
                check(cyc - clr_fall == DEAD, "R9", "clear pulse width", cyc - clr_fall, DEAD);
        end
        sclk_p = sclk; sdo_p = sdo; strobe_p = strobe; clear_p = clear_n;
    end

    // Stimulus
    initial begin
        for (int c = 0; c < NCH; c++) model[c] = '0;
        repeat (4) @(negedge clk);
        // R10: outputs during reset
        check(strobe == 1'b0, "R10", "strobe in reset", strobe, 0);
        check(clear_n == 1'b0, "R10", "clear_n in reset", clear_n, 0);
        check(sclk == 1'b0, "R10", "sclk in reset", sclk, 0);
        check(sdo == 1'b0, "R10", "sdo in reset", sdo, 0);
        push_frame();                       // frame 0: all planes zero
        @(negedge clk);
        rst_n = 1'b1;
        wait (strobe_cnt == 1);
        // Pattern A with extremes, then snapshot
        for (int c = 0; c < NCH; c++) begin
            logic [11:0] v;
            v = (c == 0) ? 12'h000 : ((c == NCH - 1) ? 12'hFFF : 12'((c * 133 + 7) % 4096));
            write_ch(c, v);
        end
        pulse_update();
        push_frame();                       // frame 1: A
        push_frame();                       // frame 2: still A (no update yet)
        wait (strobe_cnt == 13);
        // R2: pattern B written but not snapshotted
        for (int c = 0; c < NCH; c++)
            write_ch(c, 12'(((c * 158) ^ 12'hA5A) & 12'hFFF));
        wait (strobe_cnt == 30);
        // R3: mid-frame update, must wait for plane 0 of frame 3
        pulse_update();
        push_frame();                       // frame 3: B
        wait (strobe_cnt == 48);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3", "expected planes left over", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d strobes expected %0d", strobe_cnt, 48);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule